// File: doc/BRIEF.md
# Consumer-Electronics-Control Frame Transmitter

This block sends one frame on a single-wire, open-drain control bus that is shared by several devices. A caller loads a byte buffer of up to `MAX_BYTES` bytes, a byte count and a broadcast flag, then pulses `start` while the block is idle. The block lowers the wire through an active-high pull-low enable. It sends a start bit. For every byte it then sends ten slots: eight data bits, most significant first, an end-of-message slot and an acknowledge slot. All timing is counted in ticks of a one-microsecond enable, `tick_us`.

The bus is wired-AND. Because of this, the block reads the wire back while it sends its own recessive bits. A low level in one of the first four bit slots means that another initiator has won the bus. A low or high level in the acknowledge slot tells whether the destination accepted the byte. A low level at the very end of an acknowledge slot means that a receiver is signalling an error. At the end of each attempt the block gives a one-cycle `done` pulse with a 2-bit result code. Deciding when the bus has been idle long enough is the caller's task. The `line_in` input is assumed to be already synchronised to `clk`.

Top module: `cec_frame_tx`

## Requirements
- R1: The start bit drives the wire low for START_LOW_US ticks. The next slot begins START_TOTAL_US ticks after the start bit began.
- R2: Every data slot lasts BIT_TOTAL_US ticks. A logical 0 is driven low for ZERO_LOW_US ticks and a logical 1 for ONE_LOW_US ticks.
- R3: Each byte takes ten slots. Slots 0 to 7 carry data bits 7 down to 0. Slot 8 is 1 only on the last byte. Slot 9 (acknowledge) is sent as a logical 1.
- R4: In slots 0 to 3 of byte 0, when the block sends a 1, it samples the wire SAMPLE_US ticks into the slot. A low reading ends the attempt at once. The block releases the wire and reports result code 2 (arbitration lost).
- R5: The wire is not sampled for arbitration during a slot where the block sends a 0, nor during any data slot after slot 3 of byte 0. A low level from another device at those times does not change the frame or the result.
- R6: The acknowledge slot is sampled SAMPLE_US ticks into the slot. A directed frame (broadcast=0) is acknowledged when the wire reads low. A broadcast frame is acknowledged when the wire reads high.
- R7: On a missing acknowledge, the block completes the acknowledge slot, sends no further byte and reports result code 1 (NACK).
- R8: If the wire reads low on the last tick of an acknowledge slot, the block reports result code 3 (low-drive error). It then keeps `busy` high until the wire reads high again.
- R9: After the acknowledge slot of the last byte, the block reports result code 0 (OK). With a byte count of 0, it reports OK right after the start bit.
- R10: After reset, `pull_low`, `busy` and `done` are 0. A `start` sampled while idle latches the buffer, count and flag, and `busy` is 1 from the next cycle. A `start` while busy is ignored.
- R11: `done` is high for exactly one cycle per attempt, and `status` is valid in that cycle.
- R12: A byte count above MAX_BYTES is treated as MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| start | input | 1 | Request to send the presented frame |
| frame_data | input | MAX_BYTES*8 | Byte buffer, byte n at bits [8n+7:8n] |
| frame_len | input | $clog2(MAX_BYTES+1) | Number of bytes to send |
| broadcast | input | 1 | 1 when the frame is addressed to all devices |
| line_in | input | 1 | Synchronised level of the bus wire |
| pull_low | output | 1 | 1 drives the bus wire low |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | One-cycle end-of-attempt pulse |
| status | output | 2 | Result: 0 OK, 1 NACK, 2 arbitration lost, 3 low-drive |

## Verification
The bench plays the other devices on the wire, and each test pattern is meant to tell one outcome apart from the others.

- **Clean frames:** directed and broadcast frames of several lengths, including length zero and a count above capacity. These check the slot order and the pulse widths against the byte buffer, measured in clock cycles.
- **Acknowledge polarity:** the simulated receiver either holds back or pulls the wire low in a chosen acknowledge slot. This separates directed from broadcast frames, and an early NACK from a late one.
- **Arbitration:** a foreign low is placed on a sampled 1, on an unsampled 0, and on a data bit after the initiator field. Only the first of these may end the attempt.
- **Low-drive error:** a long foreign low across the end of an acknowledge slot must give code 3 with `busy` still held.

Random frames mix these four situations, and a `start` pulse is sent in the middle of a frame.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    TXS_OK     = 2'd0,
    TXS_NACK   = 2'd1,
    TXS_ARB    = 2'd2,
    TXS_LOWDRV = 2'd3
  } tx_result_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BIT   = 2'd2,
    PH_HOLD  = 2'd3
  } tx_phase_e;

  localparam int SLOT_W      = 4;
  localparam int EOM_SLOT    = 8;
  localparam int ACK_SLOT    = 9;
  localparam int ARB_SLOTS   = 4;

  // level sent in one of the ten slots of a byte
  function automatic logic slot_level(input logic [7:0] data,
                                      input logic [SLOT_W-1:0] slot,
                                      input logic last_byte);
    if (slot < SLOT_W'(EOM_SLOT))      return data[3'd7 - slot[2:0]];
    else if (slot == SLOT_W'(EOM_SLOT)) return last_byte;
    else                                return 1'b1;
  endfunction

  // slot whose recessive level is read back
  function automatic logic slot_is_sampled(input logic first_byte,
                                           input logic [SLOT_W-1:0] slot);
    return (first_byte && (slot < SLOT_W'(ARB_SLOTS))) || (slot == SLOT_W'(ACK_SLOT));
  endfunction

  // acknowledge meaning depends on addressing
  function automatic logic ack_accepted(input logic bcast, input logic level);
    return bcast ? level : !level;
  endfunction

endpackage

// File: rtl/cec_tx_slot_timer.sv
module cec_tx_slot_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] slot_len,
  output logic [CNT_W-1:0] us_cnt,
  output logic             slot_end
);

  assign slot_end = run && tick && (us_cnt == slot_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            us_cnt <= '0;
    else if (restart)      us_cnt <= '0;
    else if (run && tick)  us_cnt <= us_cnt + CNT_W'(1);
  end

endmodule

// File: rtl/cec_tx_bit_source.sv
module cec_tx_bit_source
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5,
  parameter int IDX_W     = 4
) (
  input  logic [MAX_BYTES*8-1:0] frame,
  input  logic [LEN_W-1:0]       len,
  input  logic [IDX_W-1:0]       byte_idx,
  input  logic [SLOT_W-1:0]      slot_idx,
  output logic                   bit_val,
  output logic                   last_byte,
  output logic                   ack_slot,
  output logic                   sample_slot
);

  logic [7:0] bytes [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    assign bytes[g] = frame[8*g +: 8];
  end

  assign last_byte   = (LEN_W'(byte_idx) + LEN_W'(1)) == len;
  assign ack_slot    = slot_idx == SLOT_W'(ACK_SLOT);
  assign bit_val     = slot_level(bytes[byte_idx], slot_idx, last_byte);
  assign sample_slot = slot_is_sampled(byte_idx == '0, slot_idx);

endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
  import cec_tx_pkg::*;
#(
  parameter int CNT_W          = 13,
  parameter int IDX_W          = 4,
  parameter int START_LOW_US   = 3700,
  parameter int START_TOTAL_US = 4500,
  parameter int BIT_TOTAL_US   = 2400,
  parameter int ZERO_LOW_US    = 1500,
  parameter int ONE_LOW_US     = 600,
  parameter int SAMPLE_US      = 850
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              accept,
  input  logic              len_zero,
  input  logic              bcast,
  input  logic              line_in,
  input  logic              bit_val,
  input  logic              last_byte,
  input  logic              ack_slot,
  input  logic              sample_slot,
  input  logic [CNT_W-1:0]  us_cnt,
  input  logic              slot_end,
  output logic              timer_run,
  output logic [CNT_W-1:0]  slot_len,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              pull_low,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              arb_evt,
  output logic              ack_evt,
  output logic              lowdrv_evt
);

  localparam logic [CNT_W-1:0] START_LOW_C   = CNT_W'(START_LOW_US);
  localparam logic [CNT_W-1:0] START_TOTAL_C = CNT_W'(START_TOTAL_US);
  localparam logic [CNT_W-1:0] BIT_TOTAL_C   = CNT_W'(BIT_TOTAL_US);
  localparam logic [CNT_W-1:0] ZERO_LOW_C    = CNT_W'(ZERO_LOW_US);
  localparam logic [CNT_W-1:0] ONE_LOW_C     = CNT_W'(ONE_LOW_US);
  localparam logic [CNT_W-1:0] SAMPLE_C      = CNT_W'(SAMPLE_US);

  tx_phase_e  phase;
  tx_result_e result_q;
  logic       nacked;
  logic       sample_evt;
  logic       ack_end;
  logic [CNT_W-1:0] low_len;

  assign timer_run = (phase == PH_START) || (phase == PH_BIT);
  assign slot_len  = (phase == PH_START) ? START_TOTAL_C : BIT_TOTAL_C;
  assign low_len   = (phase == PH_START) ? START_LOW_C :
                     (bit_val ? ONE_LOW_C : ZERO_LOW_C);
  assign pull_low  = timer_run && (us_cnt < low_len);

  assign sample_evt = (phase == PH_BIT) && tick && (us_cnt == SAMPLE_C) &&
                      bit_val && sample_slot;
  assign arb_evt    = sample_evt && !ack_slot && !line_in;
  assign ack_evt    = sample_evt && ack_slot;
  assign ack_end    = (phase == PH_BIT) && slot_end && ack_slot;
  assign lowdrv_evt = ack_end && !line_in;

  assign busy   = phase != PH_IDLE;
  assign status = result_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      result_q <= TXS_OK;
      byte_idx <= '0;
      slot_idx <= '0;
      nacked   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_START;
            byte_idx <= '0;
            slot_idx <= '0;
            nacked   <= 1'b0;
          end
        end
        PH_START: begin
          if (slot_end) begin
            if (len_zero) begin
              phase    <= PH_IDLE;
              done     <= 1'b1;
              result_q <= TXS_OK;
            end else begin
              phase <= PH_BIT;
            end
          end
        end
        PH_BIT: begin
          if (arb_evt) begin
            phase    <= PH_IDLE;
            done     <= 1'b1;
            result_q <= TXS_ARB;
          end else begin
            if (ack_evt && !ack_accepted(bcast, line_in)) nacked <= 1'b1;
            if (slot_end) begin
              if (ack_slot) begin
                if (!line_in) begin
                  phase    <= PH_HOLD;
                  done     <= 1'b1;
                  result_q <= TXS_LOWDRV;
                end else if (nacked) begin
                  phase    <= PH_IDLE;
                  done     <= 1'b1;
                  result_q <= TXS_NACK;
                end else if (last_byte) begin
                  phase    <= PH_IDLE;
                  done     <= 1'b1;
                  result_q <= TXS_OK;
                end else begin
                  byte_idx <= byte_idx + IDX_W'(1);
                  slot_idx <= '0;
                end
              end else begin
                slot_idx <= slot_idx + SLOT_W'(1);
              end
            end
          end
        end
        PH_HOLD: begin
          if (line_in) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES      = 16,
  parameter int START_LOW_US   = 3700,
  parameter int START_TOTAL_US = 4500,
  parameter int BIT_TOTAL_US   = 2400,
  parameter int ZERO_LOW_US    = 1500,
  parameter int ONE_LOW_US     = 600,
  parameter int SAMPLE_US      = 850,
  localparam int LEN_W         = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   start,
  input  logic [MAX_BYTES*8-1:0] frame_data,
  input  logic [LEN_W-1:0]       frame_len,
  input  logic                   broadcast,
  input  logic                   line_in,
  output logic                   pull_low,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             status
);

  localparam int IDX_W = $clog2(MAX_BYTES);
  localparam int CNT_W = $clog2(START_TOTAL_US + 1);

  logic [MAX_BYTES*8-1:0] frame_q;
  logic [LEN_W-1:0]       len_q;
  logic                   bcast_q;
  logic                   accept;

  logic [IDX_W-1:0]  byte_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic [CNT_W-1:0]  us_cnt;
  logic [CNT_W-1:0]  slot_len;
  logic timer_run, slot_end;
  logic bit_val, last_byte, ack_slot, sample_slot;
  logic arb_evt, ack_evt, lowdrv_evt;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] n);
    return (n > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : n;
  endfunction

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      len_q   <= '0;
      bcast_q <= 1'b0;
    end else if (accept) begin
      frame_q <= frame_data;
      len_q   <= clamp_len(frame_len);
      bcast_q <= broadcast;
    end
  end

  cec_tx_slot_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .run      (timer_run),
    .restart  (accept || slot_end),
    .slot_len (slot_len),
    .us_cnt   (us_cnt),
    .slot_end (slot_end)
  );

  cec_tx_bit_source #(
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .IDX_W     (IDX_W)
  ) i_bits (
    .frame       (frame_q),
    .len         (len_q),
    .byte_idx    (byte_idx),
    .slot_idx    (slot_idx),
    .bit_val     (bit_val),
    .last_byte   (last_byte),
    .ack_slot    (ack_slot),
    .sample_slot (sample_slot)
  );

  cec_tx_ctrl #(
    .CNT_W          (CNT_W),
    .IDX_W          (IDX_W),
    .START_LOW_US   (START_LOW_US),
    .START_TOTAL_US (START_TOTAL_US),
    .BIT_TOTAL_US   (BIT_TOTAL_US),
    .ZERO_LOW_US    (ZERO_LOW_US),
    .ONE_LOW_US     (ONE_LOW_US),
    .SAMPLE_US      (SAMPLE_US)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_us),
    .accept      (accept),
    .len_zero    (len_q == '0),
    .bcast       (bcast_q),
    .line_in     (line_in),
    .bit_val     (bit_val),
    .last_byte   (last_byte),
    .ack_slot    (ack_slot),
    .sample_slot (sample_slot),
    .us_cnt      (us_cnt),
    .slot_end    (slot_end),
    .timer_run   (timer_run),
    .slot_len    (slot_len),
    .byte_idx    (byte_idx),
    .slot_idx    (slot_idx),
    .pull_low    (pull_low),
    .busy        (busy),
    .done        (done),
    .status      (status),
    .arb_evt     (arb_evt),
    .ack_evt     (ack_evt),
    .lowdrv_evt  (lowdrv_evt)
  );

endmodule

// File: rtl/cec_frame_tx_chk.sv
module cec_frame_tx_chk #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic              pull_low,
  input logic              line_in,
  input logic [DATA_W-1:0] frame_q,
  input logic [CNT_W-1:0]  us_cnt,
  input logic              arb_evt,
  input logic              ack_evt,
  input logic              lowdrv_evt
);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pull_low);

  // R10
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(frame_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  arb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd2) |-> !$past(line_in));

  // R8
  lowdrv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd3) |-> busy);

  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> !busy);

  // R1
  slot_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> (us_cnt == '0));

  // R6
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_evt, ack_evt, lowdrv_evt}));

endmodule

bind cec_frame_tx cec_frame_tx_chk #(
  .DATA_W (MAX_BYTES*8),
  .CNT_W  (CNT_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .status     (status),
  .pull_low   (pull_low),
  .line_in    (line_in),
  .frame_q    (frame_q),
  .us_cnt     (us_cnt),
  .arb_evt    (arb_evt),
  .ack_evt    (ack_evt),
  .lowdrv_evt (lowdrv_evt)
);

// File: tb/test_cec_frame_tx.sv
module test_cec_frame_tx;

  localparam int MAXB = 16;
  localparam int LW   = 5;
  localparam int T_SL = 37;
  localparam int T_ST = 45;
  localparam int T_BT = 24;
  localparam int T_Z  = 15;
  localparam int T_O  = 6;
  localparam int T_S  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic start = 1'b0;
  logic broadcast = 1'b0;
  logic ext_low = 1'b0;
  logic [MAXB*8-1:0] frame_data = '0;
  logic [LW-1:0] frame_len = '0;
  logic pull_low, busy, done;
  logic [1:0] status;
  wire line_in = !(pull_low || ext_low);

  always #10 clk = ~clk;

  cec_frame_tx #(
    .MAX_BYTES(MAXB), .START_LOW_US(T_SL), .START_TOTAL_US(T_ST),
    .BIT_TOTAL_US(T_BT), .ZERO_LOW_US(T_Z), .ONE_LOW_US(T_O), .SAMPLE_US(T_S)
  ) i_cec_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
    .frame_data(frame_data), .frame_len(frame_len), .broadcast(broadcast),
    .line_in(line_in), .pull_low(pull_low), .busy(busy), .done(done), .status(status)
  );

  int checks = 0, errors = 0, cyc = 0;
  int rise_cyc [0:199];
  int low_dur  [0:199];
  int nslot = 0, cur = -1, mirror = 0;
  logic prev_pull = 1'b0;
  logic armed = 1'b0;
  int sc_nack_at = 99, sc_arb = -1, sc_ld = -1;
  logic sc_bcast = 1'b0;
  logic [7:0] mem [0:MAXB-1];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit drive_ack(input int b);
    return sc_bcast ? (b == sc_nack_at) : (b < sc_nack_at);
  endfunction

  function automatic bit respond();
    int k, b, p;
    if (!armed || cur < 1) return 1'b0;
    k = cur - 1; b = k / 10; p = k % 10;
    if (p == 9 && drive_ack(b) && mirror < T_Z) return 1'b1;
    if (k == sc_arb && mirror < T_Z) return 1'b1;
    if (p == 9 && b == sc_ld && mirror >= 20 && mirror < 60) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_bit(input int k, input int len);
    int b, p;
    b = k / 10; p = k % 10;
    if (p < 8) return int'(mem[b][7-p]);
    if (p == 8) return (b == len - 1) ? 1 : 0;
    return 1;
  endfunction

  // bus follower, tick generator and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
      if (pull_low && !prev_pull) begin
        if (nslot < 200) rise_cyc[nslot] = cyc;
        cur = nslot; nslot++; mirror = 0;
      end else if (tick_us) begin
        mirror++;
      end
      if (!pull_low && prev_pull && cur >= 0 && cur < 200) low_dur[cur] = cyc - rise_cyc[cur];
      prev_pull = pull_low;
      ext_low = respond();
      tick_us = !tick_us;
    end
  end

  task automatic run_frame(input int len_in, input bit bc, input int nack_at,
                           input int arb, input int ld, input bit poke, input string req);
    int eff, exp_st, exp_slots, w, dcyc, bad, bad_t, cls, d;
    eff = (len_in > MAXB) ? MAXB : len_in;
    sc_bcast = bc; sc_nack_at = nack_at; sc_arb = arb; sc_ld = ld;
    exp_st = 0; exp_slots = 10 * eff;
    if (eff > 0 && arb >= 0 && arb < 4 && mem[0][7-arb]) begin
      exp_st = 2; exp_slots = arb + 1;
    end else begin
      for (int b = 0; b < eff; b++) begin
        if (ld == b) begin exp_st = 3; exp_slots = 10*(b+1); break; end
        if (!(bc ? (b != nack_at) : (b < nack_at))) begin exp_st = 1; exp_slots = 10*(b+1); break; end
      end
    end
    for (int b = 0; b < MAXB; b++) frame_data[8*b +: 8] = mem[b];
    @(negedge clk);
    nslot = 0; cur = -1; armed = 1'b1;
    start = 1'b1; frame_len = LW'(len_in); broadcast = bc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (150) @(negedge clk);
      frame_data = ~frame_data; frame_len = LW'(3); broadcast = !bc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    check(done == 1'b1, "R11", "done seen", int'(done), 1);
    check(int'(status) == exp_st, req, "status code", int'(status), exp_st);
    if (exp_st == 3) begin
      check(busy == 1'b1, "R8", "busy held at low-drive", int'(busy), 1);
      dcyc = cyc;
      @(negedge clk);
      check(done == 1'b0, "R11", "done width", int'(done), 0);
      w = 0;
      while (busy && w < 2000) begin @(negedge clk); w++; end
      check((cyc - dcyc) >= 60 && !busy, "R8", "hold cycles until wire high", cyc - dcyc, 60);
    end else begin
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R11", "done width and release",
            int'(done) + int'(busy), 0);
    end
    repeat (6) @(negedge clk);
    armed = 1'b0;
    check(nslot == exp_slots + 1, (exp_st == 1) ? "R7" : "R3", "slot count", nslot, exp_slots + 1);
    check(low_dur[0] >= 2*T_SL - 1 && low_dur[0] <= 2*T_SL, "R1", "start low cycles",
          low_dur[0], 2*T_SL);
    if (nslot > 1)
      check(rise_cyc[1] - rise_cyc[0] >= 2*T_ST - 1 && rise_cyc[1] - rise_cyc[0] <= 2*T_ST,
            "R1", "start period cycles", rise_cyc[1] - rise_cyc[0], 2*T_ST);
    bad = 0; bad_t = 0;
    for (int k = 0; k < exp_slots && k + 1 < nslot; k++) begin
      d = low_dur[k+1];
      cls = (d <= 2*T_O + 1) ? 1 : 0;
      if (cls != exp_bit(k, eff)) bad++;
      if (d != (exp_bit(k, eff) ? 2*T_O : 2*T_Z)) bad_t++;
      if (k + 2 < nslot && rise_cyc[k+2] - rise_cyc[k+1] != 2*T_BT) bad_t++;
    end
    check(bad == 0, (poke ? "R10" : "R3"), "slot values vs buffer mismatches", bad, 0);
    check(bad_t == 0, "R2", "data slot timing mismatches", bad_t, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < MAXB; b++) mem[b] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pull_low == 1'b0 && busy == 1'b0 && done == 1'b0, "R10", "reset outputs",
          int'(pull_low) + int'(busy) + int'(done), 0);

    mem[0] = 8'h4F; mem[1] = 8'hA3;
    run_frame(2, 1'b0, 99, -1, -1, 1'b0, "R9");           // directed clean
    mem[0] = 8'hFF; mem[1] = 8'h36; mem[2] = 8'h01;
    run_frame(3, 1'b1, 99, -1, -1, 1'b0, "R6");           // broadcast clean: high means accepted
    run_frame(0, 1'b0, 99, -1, -1, 1'b0, "R9");           // zero length
    run_frame(3, 1'b0, 1, -1, -1, 1'b0, "R7");            // directed NACK on byte 1
    run_frame(2, 1'b1, 0, -1, -1, 1'b0, "R6");            // broadcast rejected by a follower
    mem[0] = 8'hF0;
    run_frame(2, 1'b0, 99, 2, -1, 1'b0, "R4");            // lost on sampled 1
    mem[0] = 8'hB0;
    run_frame(2, 1'b0, 99, 1, -1, 1'b0, "R5");            // foreign low on own 0
    mem[0] = 8'hFF;
    run_frame(2, 1'b0, 99, 5, -1, 1'b0, "R5");            // foreign low after initiator field
    run_frame(2, 1'b0, 99, -1, 0, 1'b0, "R8");            // receiver error low-drive
    for (int b = 0; b < MAXB; b++) mem[b] = 8'(b * 37 + 5);
    run_frame(20, 1'b0, 99, -1, -1, 1'b1, "R12");         // clamp and ignored start

    for (int i = 0; i < 10; i++) begin
      int len, mode, nk, ab, lb;
      bit bc;
      len = 1 + int'($urandom % 5);
      bc = bit'($urandom % 2);
      for (int b = 0; b < MAXB; b++) mem[b] = 8'($urandom);
      mode = int'($urandom % 4);
      nk = 99; ab = -1; lb = -1;
      if (mode == 1) nk = int'($urandom % len);
      if (mode == 2) ab = int'($urandom % 8);
      if (mode == 3) lb = int'($urandom % len);
      run_frame(len, bc, nk, ab, lb, 1'b0,
                (mode == 1) ? "R7" : (mode == 2) ? "R4" : (mode == 3) ? "R8" : "R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule